// File: doc/BRIEF.md
# Ping-Pong Triggered Capture Buffer

This block stores the sample stream of one acquisition channel in two equally sized circular memories. One memory is the active bank and takes every accepted sample. The other is the locked bank and answers read requests from a display engine. Because writes never reach the locked bank, its contents stay frozen while one video frame is drawn from it.

A one-cycle trigger pulse records the ring address of the newest sample written into the active bank. A level-type frame select input names the bank that should be active. When that level changes, the two banks swap roles, and the recorded trigger address moves into a locked-side register so that it belongs to the frozen data. Readers supply an offset counted backwards from that locked trigger address. Offset 0 is the trigger sample itself. A renderer that wants the 1,279 samples before the trigger, oldest on the left, asks for offsets 1279 down to 0. Each requested sample comes back a fixed three cycles after the request.

Top module: `pingpong_capture`

## Requirements
- R1: During and right after a synchronous active-high reset, `rd_valid` is 0, `locked_trig` is 0, bank 0 is the active bank, and the write pointer and the live trigger address are 0.
- R2: There are two banks, each holding DEPTH entries of DATA_W bits. DEPTH is a power of two. A sample is written only into the active bank, and bank 1 is active when the active index is 1.
- R3: A sample is accepted only in a cycle where `smp_valid` is 1. Each accepted sample goes to the current write pointer, which then advances by one modulo DEPTH. When `smp_valid` is 0, `smp_data` is ignored and the pointer holds.
- R4: A `trig_pulse` latches the address of the newest sample. If a sample is accepted in the same cycle, that sample's address is latched. Otherwise the address one below the write pointer is latched, modulo DEPTH.
- R5: When `frame_sel` differs from the active index, the banks swap. From the next cycle the active index equals `frame_sel`. A sample accepted in the swap cycle still goes to the bank that was active before the swap.
- R6: On a swap, `locked_trig` takes the live trigger address, including a trigger pulse in that same cycle. Between swaps `locked_trig` holds its value.
- R7: A request with offset k reads the locked bank at address (`locked_trig` − k) mod DEPTH. Offsets greater than `locked_trig` wrap around the ring.
- R8: Each request asserts `rd_valid` for exactly one cycle, three clock edges after the request edge, with the requested sample on `rd_data`. Back-to-back requests are accepted every cycle.
- R9: Samples written into the active bank while reads are in progress never change the data returned from the locked bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe; a sample is accepted when high |
| smp_data | input | DATA_W | Sample value |
| trig_pulse | input | 1 | One-cycle trigger indication |
| frame_sel | input | 1 | Level naming the bank to be active; a change swaps the roles |
| rd_req | input | 1 | Read request to the locked bank |
| rd_back | input | ADDR_W | Offset counted backwards from the locked trigger address |
| rd_valid | output | 1 | Read data valid, three cycles after the request |
| rd_data | output | DATA_W | Read sample |
| locked_trig | output | ADDR_W | Trigger address that belongs to the locked bank |

## Verification
The bench builds the block with DEPTH = 16 and DATA_W = 8. With a ring that small, every trigger position and every read offset can be covered in a short run. The write pointer wraps several times in each round, including rounds where strobe gaps fall on the trigger cycle. Sixteen rounds swap the banks back and forth, with triggers also landing on the swap cycle. Each round reads back the whole locked ring, both back-to-back and with gaps, while fresh samples stream into the active bank.

// File: rtl/pp_cap_pkg.sv
package pp_cap_pkg;
  localparam int NUM_BANKS = 2;

  typedef enum logic {
    BANK_0 = 1'b0,
    BANK_1 = 1'b1
  } bank_e;

  function automatic bank_e other_bank(input bank_e b);
    return (b == BANK_0) ? BANK_1 : BANK_0;
  endfunction
endpackage

// File: rtl/pp_sample_ram.sv
module pp_sample_ram #(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int ENTRIES = 1 << ADDR_W;

  logic [DATA_W-1:0] store [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= store[raddr];
  end
endmodule

// File: rtl/pp_write_ctrl.sv
module pp_write_ctrl
  import pp_cap_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic                 trig_pulse,
  input  logic                 frame_sel,
  output bank_e                act_bank,
  output logic [NUM_BANKS-1:0] bank_we,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [ADDR_W-1:0]    locked_trig
);
  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] live_trig;
  logic [ADDR_W-1:0] newest;
  logic [ADDR_W-1:0] live_nxt;
  logic              swap;

  // Newest sample is this cycle's write when one is accepted, else the previous one.
  assign newest   = smp_valid ? wr_ptr : (wr_ptr - ADDR_W'(1));
  assign live_nxt = trig_pulse ? newest : live_trig;
  assign swap     = (bank_e'(frame_sel) != act_bank);
  assign wr_addr  = wr_ptr;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_we
    assign bank_we[b] = smp_valid && (int'(act_bank) == b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr      <= '0;
      live_trig   <= '0;
      locked_trig <= '0;
      act_bank    <= BANK_0;
    end else begin
      if (smp_valid) wr_ptr <= wr_ptr + ADDR_W'(1);
      live_trig <= live_nxt;
      if (swap) begin
        act_bank    <= bank_e'(frame_sel);
        locked_trig <= live_nxt;
      end
    end
  end

  // R2: at most one bank takes a write in any cycle
  p_one_bank_r2: assert property (@(posedge clk) disable iff (rst) $onehot0(bank_we));
  // R3: pointer holds without a strobe
  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (rst) !smp_valid |=> $stable(wr_ptr));
  // R4: trigger with a sample latches that sample's address
  p_trig_addr_r4: assert property (@(posedge clk) disable iff (rst)
    (trig_pulse && smp_valid) |=> (live_trig == $past(wr_ptr)));
  // R5: a select mismatch makes the select level active next cycle
  p_swap_r5: assert property (@(posedge clk) disable iff (rst)
    (bank_e'(frame_sel) != act_bank) |=> (act_bank == bank_e'($past(frame_sel))));
  // R6: locked trigger address holds between swaps
  p_lock_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (bank_e'(frame_sel) == act_bank) |=> $stable(locked_trig));
endmodule

// File: rtl/pp_read_pipe.sv
module pp_read_pipe
  import pp_cap_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 11
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             rd_req,
  input  logic [ADDR_W-1:0]                rd_back,
  input  bank_e                            act_bank,
  input  logic [ADDR_W-1:0]                locked_trig,
  output logic [ADDR_W-1:0]                ram_raddr,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0] ram_rdata,
  output logic                             rd_valid,
  output logic [DATA_W-1:0]                rd_data
);
  logic              s1_v, s2_v;
  bank_e             s1_bank, s2_bank;
  logic [ADDR_W-1:0] s1_addr;

  assign ram_raddr = s1_addr;

  // Stage 1: resolve the ring address and the locked bank.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_addr <= '0;
      s1_bank <= BANK_1;
    end else begin
      s1_v    <= rd_req;
      s1_addr <= locked_trig - rd_back;
      s1_bank <= other_bank(act_bank);
    end
  end

  // Stage 2: memory read (registered inside the RAMs); Stage 3: bank mux.
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v     <= 1'b0;
      s2_bank  <= BANK_1;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      s2_v     <= s1_v;
      s2_bank  <= s1_bank;
      rd_valid <= s2_v;
      if (s2_v) rd_data <= ram_rdata[s2_bank];
    end
  end

  // R7: the bank being read is never the bank active at request time
  p_locked_side_r7: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> (s1_bank != $past(act_bank)));
endmodule

// File: rtl/pingpong_capture.sv
module pingpong_capture
  import pp_cap_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 2048,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              trig_pulse,
  input  logic              frame_sel,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_back,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] locked_trig
);
  bank_e                            act_bank;
  logic [NUM_BANKS-1:0]             bank_we;
  logic [ADDR_W-1:0]                wr_addr;
  logic [ADDR_W-1:0]                ram_raddr;
  logic [NUM_BANKS-1:0][DATA_W-1:0] ram_rdata;

  pp_write_ctrl #(.ADDR_W(ADDR_W)) u_wctl (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .trig_pulse(trig_pulse),
    .frame_sel(frame_sel), .act_bank(act_bank), .bank_we(bank_we),
    .wr_addr(wr_addr), .locked_trig(locked_trig)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pp_sample_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .clk(clk), .we(bank_we[b]), .waddr(wr_addr), .wdata(smp_data),
      .raddr(ram_raddr), .rdata(ram_rdata[b])
    );
  end

  pp_read_pipe #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rpipe (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_back(rd_back),
    .act_bank(act_bank), .locked_trig(locked_trig), .ram_raddr(ram_raddr),
    .ram_rdata(ram_rdata), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R8: a request yields valid three edges later, and valid only follows a request
  p_lat_fwd_r8: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> ##3 rd_valid);
  p_lat_back_r8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_req, 3));
  // R1: reset clears the output valid
  p_reset_r1: assert property (@(posedge clk) rst |=> !rd_valid);
endmodule

// File: tb/pingpong_capture_bench.sv
module pingpong_capture_bench;
  localparam int W = 8;
  localparam int D = 16;
  localparam int AW = $clog2(D);
  localparam int M = D - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0, trig_pulse = 1'b0, frame_sel = 1'b0, rd_req = 1'b0;
  logic [W-1:0] smp_data = '0;
  logic [AW-1:0] rd_back = '0;
  logic rd_valid;
  logic [W-1:0] rd_data;
  logic [AW-1:0] locked_trig;

  always #5 clk = ~clk;

  pingpong_capture #(.DATA_W(W), .DEPTH(D)) u_pingpong_capture (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .trig_pulse(trig_pulse), .frame_sel(frame_sel), .rd_req(rd_req),
    .rd_back(rd_back), .rd_valid(rd_valid), .rd_data(rd_data),
    .locked_trig(locked_trig)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Requirement-level model.
  logic [W-1:0] m_mem [2][D];
  int m_act = 0, m_wptr = 0, m_live = 0, m_ltrig = 0;
  logic         pv [3] = '{0, 0, 0};
  logic [W-1:0] pd [3];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [W-1:0] d, input logic t,
                      input logic s, input logic q, input int off);
    logic [W-1:0] ed;
    int newest, nlive;
    @(negedge clk);
    smp_valid = v; smp_data = d; trig_pulse = t; frame_sel = s;
    rd_req = q; rd_back = AW'(off);
    ed = m_mem[1 - m_act][(m_ltrig - off) & M];
    newest = v ? m_wptr : ((m_wptr - 1) & M);
    nlive = t ? newest : m_live;
    if (v) begin
      m_mem[m_act][m_wptr] = d;
      m_wptr = (m_wptr + 1) & M;
    end
    if (int'(s) != m_act) begin
      m_ltrig = nlive;
      m_act = int'(s);
    end
    m_live = nlive;
    pv[2] = pv[1]; pd[2] = pd[1];
    pv[1] = pv[0]; pd[1] = pd[0];
    pv[0] = q;     pd[0] = ed;
    @(posedge clk); #1;
    check(rd_valid == pv[2], "R8 rd_valid timing", int'(rd_valid), int'(pv[2]));
    if (pv[2]) check(rd_data == pd[2], "R2 R7 R9 read data", int'(rd_data), int'(pd[2]));
    check(int'(locked_trig) == m_ltrig, "R4 R5 R6 locked_trig", int'(locked_trig), m_ltrig);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic sel;
    sel = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: state right after reset
    check(rd_valid == 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);
    check(locked_trig == '0, "R1 locked_trig after reset", int'(locked_trig), 0);
    for (int r = 0; r < 16; r++) begin
      // Fill the active bank with wraps, strobe gaps (R3) and a trigger (R4).
      for (int i = 0; i < D + r + 4; i++) begin
        logic vv;
        vv = (i % 5) != 4;
        step(vv, vv ? W'(i * 37 + r * 11 + 5) : 8'hEE, i == r, sel, 1'b0, 0);
      end
      // Swap roles (R5); odd rounds also trigger in the swap cycle (R6).
      sel = ~sel;
      step(1'b1, W'(r * 13 + 1), r[0], sel, 1'b0, 0);
      // Read every offset (R7 wrap) while new samples stream in (R9).
      for (int k = 0; k < D; k++) begin
        step(1'b1, W'(k * 5 + r), 1'b0, sel, 1'b1, (D - 1) - k);
        if (r[0]) step(1'b1, W'(k + 99), 1'b0, sel, 1'b0, 0);
      end
      repeat (4) step(1'b0, 8'h55, 1'b0, sel, 1'b0, 0);
    end
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule